// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves data between two ports, A and B, in both directions. The port width is split into independent lanes, called halves, of eight bits each. Every half has one storage bank for the A-to-B direction and another for the B-to-A direction. Each direction has three active-low controls: an enable, a capture-open control and a drive control. The enable gates both capture and drive. The capture-open control decides whether the bank follows its source port or holds. The drive control decides whether the destination port is driven.

The design models the three-state pins as separate input, output and output-enable signals for each port. There is one output-enable bit per half and per port, so a pad ring or bus fabric outside the block can build the real three-state drivers. Capture is sampled on the block clock. While a bank is open, its output follows the source port with no register in the path. A bank takes a new value at each clock edge while it is open. Once the capture-open control rises, the bank keeps the value it took at the last edge of its open phase.

The ports are plain level controls and data. There is no valid/ready handshake, so a destination port cannot push back on its source. The user must keep both capture-open and enable steady around a closing edge for as long as the held value matters.

Top module: `bxcvr_top`

## Requirements
- R1: The output-enable bit of the B port for a half is 1 exactly when that half's A-to-B enable and A-to-B drive control are both 0 and reset is not asserted. The output-enable bit of the A port uses the B-to-A enable and drive controls in the same way.
- R2: While the A-to-B enable and capture-open controls of a half are both 0, that half's B data output equals its A data input in the same cycle.
- R3: When the A-to-B capture-open control of a half goes from 0 to 1, and the enable was 0 in the cycle before, the B data output keeps the A value that was present at the last clock edge before the change.
- R4: While the A-to-B capture-open control of a half is 1, the stored value and the B data output do not change, whatever the A input does.
- R5: While the A-to-B enable of a half is 1, the stored value does not change and the B output-enable bit is 0, even when the capture-open and drive controls are 0.
- R6: The B-to-A direction follows R2 to R5, using its own three controls, with B as the source port and A as the destination port.
- R7: The two halves are independent. Controls and data on one half never change the outputs of the other half.
- R8: Both directions of one half can hold different values at the same time, and each direction keeps its own value.
- R9: While reset is asserted (rst_n = 0), every output-enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low reset |
| ab_ce_n | input | 2 | A-to-B enable for each half, active low |
| ab_le_n | input | 2 | A-to-B capture-open control for each half, active low |
| ab_oe_n | input | 2 | A-to-B drive control for each half, active low |
| ba_ce_n | input | 2 | B-to-A enable for each half, active low |
| ba_le_n | input | 2 | B-to-A capture-open control for each half, active low |
| ba_oe_n | input | 2 | B-to-A drive control for each half, active low |
| a_in | input | 16 | A port data in; bits 7:0 belong to half 0 |
| a_out | output | 16 | A port data out, from the B-to-A bank |
| a_oe | output | 2 | A port drive enable for each half, active high |
| b_in | input | 16 | B port data in; bits 7:0 belong to half 0 |
| b_out | output | 16 | B port data out, from the A-to-B bank |
| b_oe | output | 2 | B port drive enable for each half, active high |

## Verification
A corrupted bank shows up on the destination data output in the first cycle after a closing edge, and it stays wrong for as long as the bank holds. A bank that captures while it should hold shows up at the next clock edge, as a change in the output while the source port moves. A wrong enable decode shows up at once as a wrong output-enable bit, with no clock edge in between. When both directions of one half drive at the same time, the bench reports a contention warning, because each half then drives both of its ports.

// File: rtl/bxcvr_pkg.sv
`timescale 1ns/1ps
package bxcvr_pkg;
  localparam int HALVES = 2;
  localparam int LANE_W = 8;
  localparam int BUS_W  = HALVES * LANE_W;

  // one direction's active-low controls
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/bxcvr_dir.sv
`timescale 1ns/1ps
module bxcvr_dir
  import bxcvr_pkg::*;
#(
  parameter int W = LANE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dir_ctrl_t    ctl,
  input  logic [W-1:0] src,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic [W-1:0] store_q;
  logic         open;

  assign open = !ctl.ce_n && !ctl.le_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    store_q <= '0;
    else if (open) store_q <= src;
  end

  assign dout  = open ? src : store_q;
  assign drive = rst_n && !ctl.ce_n && !ctl.oe_n;
endmodule

// File: rtl/bxcvr_half.sv
`timescale 1ns/1ps
module bxcvr_half
  import bxcvr_pkg::*;
#(
  parameter int W = LANE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dir_ctrl_t    ab_ctl,
  input  dir_ctrl_t    ba_ctl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         a_oe,
  output logic         b_oe
);
  bxcvr_dir #(.W(W)) u_ab (
    .clk(clk), .rst_n(rst_n), .ctl(ab_ctl),
    .src(a_in), .dout(b_out), .drive(b_oe)
  );

  bxcvr_dir #(.W(W)) u_ba (
    .clk(clk), .rst_n(rst_n), .ctl(ba_ctl),
    .src(b_in), .dout(a_out), .drive(a_oe)
  );
endmodule

// File: rtl/bxcvr_top.sv
`timescale 1ns/1ps
module bxcvr_top
  import bxcvr_pkg::*;
#(
  parameter int NH = HALVES,
  parameter int LW = LANE_W,
  localparam int DW = NH * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NH-1:0] ab_ce_n,
  input  logic [NH-1:0] ab_le_n,
  input  logic [NH-1:0] ab_oe_n,
  input  logic [NH-1:0] ba_ce_n,
  input  logic [NH-1:0] ba_le_n,
  input  logic [NH-1:0] ba_oe_n,
  input  logic [DW-1:0] a_in,
  output logic [DW-1:0] a_out,
  output logic [NH-1:0] a_oe,
  input  logic [DW-1:0] b_in,
  output logic [DW-1:0] b_out,
  output logic [NH-1:0] b_oe
);
  for (genvar h = 0; h < NH; h++) begin : g_half
    dir_ctrl_t ab_c, ba_c;
    assign ab_c = '{ce_n: ab_ce_n[h], le_n: ab_le_n[h], oe_n: ab_oe_n[h]};
    assign ba_c = '{ce_n: ba_ce_n[h], le_n: ba_le_n[h], oe_n: ba_oe_n[h]};

    bxcvr_half #(.W(LW)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .ab_ctl(ab_c),
      .ba_ctl(ba_c),
      .a_in  (a_in[h*LW +: LW]),
      .b_in  (b_in[h*LW +: LW]),
      .a_out (a_out[h*LW +: LW]),
      .b_out (b_out[h*LW +: LW]),
      .a_oe  (a_oe[h]),
      .b_oe  (b_oe[h])
    );
  end
endmodule

// File: rtl/bxcvr_chk.sv
`timescale 1ns/1ps
module bxcvr_chk #(
  parameter int NH = 2,
  parameter int LW = 8,
  localparam int DW = NH * LW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NH-1:0] ab_ce_n,
  input logic [NH-1:0] ab_le_n,
  input logic [NH-1:0] ab_oe_n,
  input logic [NH-1:0] ba_ce_n,
  input logic [NH-1:0] ba_le_n,
  input logic [NH-1:0] ba_oe_n,
  input logic [DW-1:0] a_in,
  input logic [DW-1:0] a_out,
  input logic [NH-1:0] a_oe,
  input logic [DW-1:0] b_in,
  input logic [DW-1:0] b_out,
  input logic [NH-1:0] b_oe
);
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> (a_oe == '0 && b_oe == '0));

  for (genvar h = 0; h < NH; h++) begin : g_chk
    assert_ce_blocks_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ab_ce_n[h] |-> !b_oe[h]);
    assert_ce_blocks_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ba_ce_n[h] |-> !a_oe[h]);
    assert_drive_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_ce_n[h] && !ab_oe_n[h]) |-> b_oe[h]);
    assert_flow_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_ce_n[h] && !ab_le_n[h]) |-> b_out[h*LW +: LW] == a_in[h*LW +: LW]);
    assert_flow_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_ce_n[h] && !ba_le_n[h]) |-> a_out[h*LW +: LW] == b_in[h*LW +: LW]);
    assert_capture_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ab_le_n[h]) && $past(!ab_ce_n[h]))
        |-> b_out[h*LW +: LW] == $past(a_in[h*LW +: LW]));
    assert_hold_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_le_n[h] && $past(ab_le_n[h])) |-> $stable(b_out[h*LW +: LW]));
    assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_ce_n[h] && $past(ab_ce_n[h])) |-> $stable(b_out[h*LW +: LW]));
    assert_hold_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_le_n[h] && $past(ba_le_n[h])) |-> $stable(a_out[h*LW +: LW]));
  end
endmodule

bind bxcvr_top bxcvr_chk #(.NH(NH), .LW(LW)) u_chk (.*);

// File: tb/tb_bxcvr_top.sv
`timescale 1ns/1ps
module tb_bxcvr_top;
  localparam int NH = 2;
  localparam int LW = 8;
  localparam int DW = NH * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NH-1:0] ab_ce_n = '1, ab_le_n = '1, ab_oe_n = '1;
  logic [NH-1:0] ba_ce_n = '1, ba_le_n = '1, ba_oe_n = '1;
  logic [DW-1:0] a_in = '0, b_in = '0;
  logic [DW-1:0] a_out, b_out;
  logic [NH-1:0] a_oe, b_oe;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bxcvr_top dut (.*);

  // reference banks, with a flag telling whether each holds a known value
  logic [LW-1:0] m_ab [NH];
  logic [LW-1:0] m_ba [NH];
  bit            k_ab [NH];
  bit            k_ba [NH];

  always @(posedge clk) begin
    for (int h = 0; h < NH; h++) begin
      if (!rst_n) begin
        k_ab[h] <= 1'b0;
        k_ba[h] <= 1'b0;
      end else begin
        if (!ab_ce_n[h] && !ab_le_n[h]) begin m_ab[h] <= a_in[h*LW +: LW]; k_ab[h] <= 1'b1; end
        if (!ba_ce_n[h] && !ba_le_n[h]) begin m_ba[h] <= b_in[h*LW +: LW]; k_ba[h] <= 1'b1; end
      end
    end
  end

  function automatic bit exp_drive(input logic ce, input logic oe);
    return rst_n && !ce && !oe;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare every output with the reference model
  task automatic check_all();
    for (int h = 0; h < NH; h++) begin
      chk("R1", DW'(b_oe[h]), DW'(exp_drive(ab_ce_n[h], ab_oe_n[h])));
      chk("R6", DW'(a_oe[h]), DW'(exp_drive(ba_ce_n[h], ba_oe_n[h])));
      if (a_oe[h] && b_oe[h])
        $display("WARN contention: half %0d drives A and B at once", h);
      if (!ab_ce_n[h] && !ab_le_n[h])
        chk("R2", DW'(b_out[h*LW +: LW]), DW'(a_in[h*LW +: LW]));
      else if (k_ab[h])
        chk(ab_ce_n[h] ? "R5" : "R4", DW'(b_out[h*LW +: LW]), DW'(m_ab[h]));
      if (!ba_ce_n[h] && !ba_le_n[h])
        chk("R6", DW'(a_out[h*LW +: LW]), DW'(b_in[h*LW +: LW]));
      else if (k_ba[h])
        chk("R6", DW'(a_out[h*LW +: LW]), DW'(m_ba[h]));
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // reset: drive controls all active, yet no enable may rise (R9)
    ab_ce_n = '0; ab_oe_n = '0; ba_ce_n = '0; ba_oe_n = '0;
    repeat (3) settle();
    #1;
    chk("R9", DW'(a_oe), '0);
    chk("R9", DW'(b_oe), '0);
    settle();
    rst_n = 1'b1;
    ab_ce_n = '1; ab_oe_n = '1; ba_ce_n = '1; ba_oe_n = '1;

    // R3: open half 0 A-to-B, load 5A, close, change A
    settle(); ab_ce_n[0] = 0; ab_le_n[0] = 0; ab_oe_n[0] = 0; a_in[7:0] = 8'h5A;
    #1; chk("R2", DW'(b_out[7:0]), DW'(8'h5A));
    settle(); ab_le_n[0] = 1; a_in[7:0] = 8'hC3;
    #1; chk("R3", DW'(b_out[7:0]), DW'(8'h5A));
    chk("R1", DW'(b_oe[0]), DW'(1'b1));
    settle(); a_in[7:0] = 8'h0F;
    #1; chk("R4", DW'(b_out[7:0]), DW'(8'h5A));

    // R5: disabled with capture open must neither capture nor drive
    settle(); ab_ce_n[0] = 1; ab_le_n[0] = 0; a_in[7:0] = 8'h11;
    #1; chk("R5", DW'(b_oe[0]), DW'(1'b0));
    settle(); ab_ce_n[0] = 0; ab_le_n[0] = 1;
    #1; chk("R5", DW'(b_out[7:0]), DW'(8'h5A));

    // R8: B-to-A of half 0 loads 96 and holds next to A-to-B holding 5A
    settle(); ba_ce_n[0] = 0; ba_le_n[0] = 0; b_in[7:0] = 8'h96;
    settle(); ba_le_n[0] = 1; b_in[7:0] = 8'h00; a_in[7:0] = 8'hFF;
    #1; chk("R8", DW'(a_out[7:0]), DW'(8'h96));
    chk("R8", DW'(b_out[7:0]), DW'(8'h5A));

    // R7: half 1 loads and streams while half 0 holds
    settle(); ab_ce_n[1] = 0; ab_le_n[1] = 0; ab_oe_n[1] = 0; a_in[15:8] = 8'hA5;
    #1; chk("R7", DW'(b_out[15:8]), DW'(8'hA5));
    chk("R7", DW'(b_out[7:0]), DW'(8'h5A));
    chk("R7", DW'(b_oe[0]), DW'(1'b1));
    settle(); a_in[15:8] = 8'h3C;
    #1; chk("R7", DW'(b_out[7:0]), DW'(8'h5A));
    chk("R7", DW'(a_out[7:0]), DW'(8'h96));

    // random phase, controls biased towards active
    for (int i = 0; i < 4000; i++) begin
      settle();
      for (int h = 0; h < NH; h++) begin
        ab_ce_n[h] = ($urandom % 4) == 0;
        ab_le_n[h] = ($urandom % 3) == 0;
        ab_oe_n[h] = ($urandom % 3) == 0;
        ba_ce_n[h] = ($urandom % 4) == 0;
        ba_le_n[h] = ($urandom % 3) == 0;
        ba_oe_n[h] = ($urandom % 3) == 0;
      end
      a_in = DW'($urandom);
      b_in = DW'($urandom);
      #1; check_all();
    end
    finish_run();
  end
endmodule